// File: doc/BRIEF.md
# Power-Managed System Clock Source Controller

This block decides which of three oscillators feeds the system clock: the primary oscillator, the secondary timer oscillator, or an internal oscillator block whose output passes through a selectable postscaler. Software programs a source choice, a frequency choice and an idle-enable bit through a single configuration write port. The source choice is only staged. It is applied when a sleep request arrives, and that request also puts the device into a power-managed mode.

A sleep request that targets the secondary oscillator while that oscillator is disabled is refused as a whole. The active source and the power-managed state both stay as they were. A change of frequency choice reaches the postscaler tap select on the next clock, with no sleep request needed. Three status flags report the active source once it is ready. At most one flag is set at a time. With all three clear, either the low-frequency internal source is running or the internal block has not yet become stable. The idle-enable bit gates the CPU only while the device is in a power-managed mode. A wake strobe ends that mode.

Top module: `sysclk_ctrl`

## Requirements
- R1: While rst_n is low the block holds src_onehot = 3'b001 (primary active), tap_sel = one-hot bit 0, all status flags clear, pm_mode = 0 and cpu_gate = 0.
- R2: A configuration write (cfg_we) of cfg_src_sel without a sleep request leaves src_onehot unchanged.
- R3: When sleep_req is high at a clock edge, src_onehot shows the staged source after that edge, with this encoding: 00 selects primary (src_onehot bit 0), 01 selects secondary (bit 1), 10 or 11 selects internal (bit 2). pm_mode becomes 1 at the same edge.
- R4: A sleep request whose staged source is 01 while sec_osc_en is low changes neither src_onehot nor pm_mode.
- R5: tap_sel is one-hot, and its set bit index equals the frequency code, from 7 (undivided 8 MHz) down through 1 (125 kHz) to 0 (~31 kHz source). It follows a write on the next edge whether or not a sleep request occurs.
- R6: stat_pri, stat_sec and stat_int are each set one edge after their source is active and that source's ready input (pri_ready, sec_ready, int_stable) is high.
- R7: At most one status flag is ever set. At a source switch the old flag clears on the same edge.
- R8: While the internal source is active with frequency code 0, all three status flags are clear.
- R9: Every reset clears the staged source to 00, so a sleep request after reset keeps the primary source.
- R10: cpu_gate is high exactly when pm_mode and the written idle-enable bit are both 1. wake clears pm_mode on the next edge, and sleep_req takes priority if both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for all configuration fields |
| cfg_src_sel | input | 2 | Staged source: 00 primary, 01 secondary, 1x internal |
| cfg_freq_sel | input | 3 | Internal frequency code, 7 = 8 MHz down to 0 = ~31 kHz |
| cfg_idle_en | input | 1 | Idle-enable bit for CPU gating in power-managed mode |
| sleep_req | input | 1 | Sleep strobe that commits the staged source |
| wake | input | 1 | Strobe that leaves power-managed mode |
| sec_osc_en | input | 1 | Secondary oscillator enable |
| pri_ready | input | 1 | Primary start-up timer expired |
| int_stable | input | 1 | Internal oscillator block stable |
| sec_ready | input | 1 | Secondary oscillator running |
| src_onehot | output | 3 | One-hot clock mux select (0 primary, 1 secondary, 2 internal) |
| tap_sel | output | 8 | One-hot postscaler tap select, bit index = frequency code |
| stat_pri | output | 1 | Primary source active and ready |
| stat_int | output | 1 | Internal block active, stable, and not on the low-frequency source |
| stat_sec | output | 1 | Secondary source active and running |
| pm_mode | output | 1 | Power-managed mode in effect |
| cpu_gate | output | 1 | CPU gating request |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. The tap select follows a configuration write after one edge, as do the mux select and pm_mode after a sleep strobe and a status flag after a ready input changes. The bench drives all inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. To check that something is ignored or refused, it samples the same outputs after that edge and compares them with their values before the stimulus.

// File: rtl/sysclk_pkg.sv
// Shared types for the system clock source controller.
package sysclk_pkg;
    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_INT = 2'd2
    } src_e;

    // Map the 2-bit staged field to a source: 00 primary, 01 secondary, 1x internal.
    function automatic src_e decode_src(input logic [1:0] sel);
        if (sel[1])      return SRC_INT;
        else if (sel[0]) return SRC_SEC;
        else             return SRC_PRI;
    endfunction
endpackage

// File: rtl/sysclk_regs.sv
// Configuration register bank. It holds the staged source field, the internal
// frequency code and the idle-enable bit. Assumes one write strobe loads all
// fields together. It also exposes the next-state frequency code so that
// status logic sees a code change on the same edge as the register.
module sysclk_regs #(
    parameter int FSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_src_sel,
    input  logic [FSEL_W-1:0] cfg_freq_sel,
    input  logic              cfg_idle_en,
    output logic [1:0]        src_sel_q,
    output logic [FSEL_W-1:0] freq_q,
    output logic [FSEL_W-1:0] freq_nxt,
    output logic              idle_q
);
    // Next value of the frequency code.
    always_comb begin
        freq_nxt = cfg_we ? cfg_freq_sel : freq_q;
    end

    // Load the fields on a write and clear them on every reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel_q <= 2'b00;
            freq_q    <= '0;
            idle_q    <= 1'b0;
        end else begin
            freq_q <= freq_nxt;
            if (cfg_we) begin
                src_sel_q <= cfg_src_sel;
                idle_q    <= cfg_idle_en;
            end
        end
    end
endmodule

// File: rtl/sysclk_commit.sv
// Commit sequencer. A sleep strobe applies the staged source and enters
// power-managed mode. A request that targets a disabled secondary oscillator
// is refused completely. A wake strobe leaves power-managed mode, and sleep
// wins when both strobes are high.
module sysclk_commit
    import sysclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake,
    input  logic       sec_osc_en,
    input  logic [1:0] src_sel_q,
    output src_e       act_q,
    output src_e       act_nxt,
    output logic       pm_q
);
    src_e target;
    logic accept;
    logic pm_nxt;

    // Decide whether the sleep request is honoured and form the next state.
    always_comb begin
        target  = decode_src(src_sel_q);
        accept  = sleep_req && !((target == SRC_SEC) && !sec_osc_en);
        act_nxt = accept ? target : act_q;
        if (accept)    pm_nxt = 1'b1;
        else if (wake) pm_nxt = 1'b0;
        else           pm_nxt = pm_q;
    end

    // Hold the active source and the mode; the primary source after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= SRC_PRI;
            pm_q  <= 1'b0;
        end else begin
            act_q <= act_nxt;
            pm_q  <= pm_nxt;
        end
    end
endmodule

// File: rtl/sysclk_status.sv
// Status flags for the active source. Each flag is computed from the
// next-state source, so a switch clears the old flag on the same edge as the
// switch. A new flag waits for that source's ready input. The internal flag
// stays clear while the low-frequency code (0) is selected.
module sysclk_status
    import sysclk_pkg::*;
#(
    parameter int FSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_e              act_nxt,
    input  logic [FSEL_W-1:0] freq_nxt,
    input  logic              pri_ready,
    input  logic              int_stable,
    input  logic              sec_ready,
    output logic              stat_pri,
    output logic              stat_int,
    output logic              stat_sec
);
    // Register each flag from the next-state source and its ready input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_pri <= 1'b0;
            stat_int <= 1'b0;
            stat_sec <= 1'b0;
        end else begin
            stat_pri <= (act_nxt == SRC_PRI) && pri_ready;
            stat_sec <= (act_nxt == SRC_SEC) && sec_ready;
            stat_int <= (act_nxt == SRC_INT) && int_stable && (freq_nxt != '0);
        end
    end
endmodule

// File: rtl/sysclk_ctrl.sv
// Top of the system clock source controller. It connects the register bank,
// the commit sequencer and the status flags, and decodes the one-hot mux
// select and the postscaler tap select. Assumes all inputs are synchronous
// to clk.
module sysclk_ctrl
    import sysclk_pkg::*;
#(
    parameter int NUM_TAPS = 8,
    localparam int FSEL_W = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_src_sel,
    input  logic [FSEL_W-1:0]   cfg_freq_sel,
    input  logic                cfg_idle_en,
    input  logic                sleep_req,
    input  logic                wake,
    input  logic                sec_osc_en,
    input  logic                pri_ready,
    input  logic                int_stable,
    input  logic                sec_ready,
    output logic [NUM_SRC-1:0]  src_onehot,
    output logic [NUM_TAPS-1:0] tap_sel,
    output logic                stat_pri,
    output logic                stat_int,
    output logic                stat_sec,
    output logic                pm_mode,
    output logic                cpu_gate
);
    logic [1:0]        src_sel_q;
    logic [FSEL_W-1:0] freq_q;
    logic [FSEL_W-1:0] freq_nxt;
    logic              idle_q;
    src_e              act_q;
    src_e              act_nxt;

    sysclk_regs #(.FSEL_W(FSEL_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_src_sel  (cfg_src_sel),
        .cfg_freq_sel (cfg_freq_sel),
        .cfg_idle_en  (cfg_idle_en),
        .src_sel_q    (src_sel_q),
        .freq_q       (freq_q),
        .freq_nxt     (freq_nxt),
        .idle_q       (idle_q)
    );

    sysclk_commit u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake       (wake),
        .sec_osc_en (sec_osc_en),
        .src_sel_q  (src_sel_q),
        .act_q      (act_q),
        .act_nxt    (act_nxt),
        .pm_q       (pm_mode)
    );

    sysclk_status #(.FSEL_W(FSEL_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_nxt    (act_nxt),
        .freq_nxt   (freq_nxt),
        .pri_ready  (pri_ready),
        .int_stable (int_stable),
        .sec_ready  (sec_ready),
        .stat_pri   (stat_pri),
        .stat_int   (stat_int),
        .stat_sec   (stat_sec)
    );

    // One-hot mux select from the active source.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign src_onehot[k] = (act_q == src_e'(k));
    end

    // One-hot postscaler tap; it follows the code without a sleep request.
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_sel[i] = (freq_q == FSEL_W'(i));
    end

    // Gate the CPU only in power-managed mode with idle enabled.
    assign cpu_gate = pm_mode && idle_q;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
// Assertion checker for sysclk_ctrl, attached with bind.
module sysclk_ctrl_chk #(
    parameter int NUM_TAPS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sleep_req,
    input logic                sec_osc_en,
    input logic [1:0]          src_sel_q,
    input logic [2:0]          src_onehot,
    input logic [NUM_TAPS-1:0] tap_sel,
    input logic                stat_pri,
    input logic                stat_int,
    input logic                stat_sec,
    input logic                pm_mode,
    input logic                cpu_gate
);
    // R7
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_pri, stat_int, stat_sec}));

    // R3
    mux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_onehot) == 1);

    // R2
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_req |=> $stable(src_onehot));

    // R4
    sec_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !sec_osc_en && src_sel_q == 2'b01)
            |=> ($stable(src_onehot) && $stable(pm_mode)));

    // R5
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1);

    // R6
    pri_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pri |-> src_onehot[0]);

    // R6
    sec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_sec |-> src_onehot[1]);

    // R6
    int_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_int |-> src_onehot[2]);

    // R10
    gate_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gate |-> pm_mode);
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .sec_osc_en (sec_osc_en),
    .src_sel_q  (src_sel_q),
    .src_onehot (src_onehot),
    .tap_sel    (tap_sel),
    .stat_pri   (stat_pri),
    .stat_int   (stat_int),
    .stat_sec   (stat_sec),
    .pm_mode    (pm_mode),
    .cpu_gate   (cpu_gate)
);

// File: tb/tb_sysclk_ctrl.sv
module tb_sysclk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [1:0] cfg_src_sel;
    logic [2:0] cfg_freq_sel;
    logic       cfg_idle_en;
    logic       sleep_req;
    logic       wake;
    logic       sec_osc_en;
    logic       pri_ready;
    logic       int_stable;
    logic       sec_ready;
    logic [2:0] src_onehot;
    logic [7:0] tap_sel;
    logic       stat_pri;
    logic       stat_int;
    logic       stat_sec;
    logic       pm_mode;
    logic       cpu_gate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sysclk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src_sel(cfg_src_sel),
        .cfg_freq_sel(cfg_freq_sel), .cfg_idle_en(cfg_idle_en),
        .sleep_req(sleep_req), .wake(wake), .sec_osc_en(sec_osc_en),
        .pri_ready(pri_ready), .int_stable(int_stable), .sec_ready(sec_ready),
        .src_onehot(src_onehot), .tap_sel(tap_sel), .stat_pri(stat_pri),
        .stat_int(stat_int), .stat_sec(stat_sec), .pm_mode(pm_mode),
        .cpu_gate(cpu_gate)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One rising edge, then return on the falling edge for sampling/driving.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cfg_we = 0; sleep_req = 0; wake = 0;
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [2:0] f, input logic ie);
        cfg_we = 1; cfg_src_sel = s; cfg_freq_sel = f; cfg_idle_en = ie;
        step();
        cfg_we = 0;
    endtask

    task automatic do_sleep();
        sleep_req = 1;
        step();
        sleep_req = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        step(); step();
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk("R1 src_onehot", src_onehot, 3'b001);
        chk("R1 tap_sel", tap_sel, 8'h01);
        chk("R1 flags", {stat_pri, stat_int, stat_sec}, 0);
        chk("R1 pm_mode/cpu_gate", {pm_mode, cpu_gate}, 0);
        rst_n = 1;
        step();
        chk("R6 primary flag after ready", stat_pri, 1);
    endtask

    // R2: staging without sleep has no effect on the mux
    task automatic t_stage_only();
        cfg_write(2'b10, 3'd7, 0);
        chk("R2 src unchanged after write", src_onehot, 3'b001);
        step();
        chk("R2 src still unchanged", src_onehot, 3'b001);
    endtask

    // R3, R7, R6: commit to internal, old flag clears, new waits for stable
    task automatic t_commit_internal();
        int_stable = 0;
        do_sleep();
        chk("R3 internal committed", src_onehot, 3'b100);
        chk("R3 pm_mode set", pm_mode, 1);
        chk("R7 old flag cleared at switch", {stat_pri, stat_int, stat_sec}, 0);
        int_stable = 1;
        step();
        chk("R6 internal flag after stable", {stat_pri, stat_int, stat_sec}, 3'b010);
    endtask

    // R5, R8: frequency change without sleep; low-frequency code clears flags
    task automatic t_freq();
        for (int f = 6; f >= 0; f--) begin
            cfg_write(2'b11, 3'(f), 0);
            chk("R5 tap follows code", tap_sel, 1 << f);
        end
        chk("R8 all flags clear on low-frequency code", {stat_pri, stat_int, stat_sec}, 0);
        chk("R3 code 11 keeps internal", src_onehot, 3'b100);
        cfg_write(2'b11, 3'd4, 0);
        chk("R8 internal flag back on", stat_int, 1);
    endtask

    // R4: secondary refused while disabled, then accepted
    task automatic t_secondary();
        wake = 1; step(); wake = 0;
        chk("R10 wake clears pm_mode", pm_mode, 0);
        sec_osc_en = 0; sec_ready = 1;
        cfg_write(2'b01, 3'd4, 0);
        do_sleep();
        chk("R4 refused source", src_onehot, 3'b100);
        chk("R4 refused mode", pm_mode, 0);
        sec_osc_en = 1;
        do_sleep();
        chk("R3 secondary committed", src_onehot, 3'b010);
        chk("R7 secondary flag only", {stat_pri, stat_int, stat_sec}, 3'b001);
        cfg_write(2'b00, 3'd4, 0);
        do_sleep();
        chk("R3 primary committed", src_onehot, 3'b001);
        chk("R7 primary flag only", {stat_pri, stat_int, stat_sec}, 3'b100);
    endtask

    // R9: reset clears the staged field
    task automatic t_reset_clears();
        cfg_write(2'b10, 3'd7, 0);
        do_reset();
        rst_n = 1;
        step();
        do_sleep();
        chk("R9 staged field cleared", src_onehot, 3'b001);
    endtask

    // R10: CPU gating
    task automatic t_gate();
        wake = 1; step(); wake = 0;
        cfg_write(2'b00, 3'd0, 1);
        chk("R10 no gate outside mode", cpu_gate, 0);
        sleep_req = 1; wake = 1;
        step();
        sleep_req = 0; wake = 0;
        chk("R10 sleep wins over wake", pm_mode, 1);
        chk("R10 gate in mode", cpu_gate, 1);
        cfg_write(2'b00, 3'd0, 0);
        chk("R10 gate off with idle clear", cpu_gate, 0);
        cfg_write(2'b00, 3'd0, 1);
        wake = 1; step(); wake = 0;
        chk("R10 gate off after wake", {pm_mode, cpu_gate}, 0);
    endtask

    initial begin
        rst_n = 0; cfg_src_sel = 0; cfg_freq_sel = 0; cfg_idle_en = 0;
        sec_osc_en = 0; pri_ready = 1; int_stable = 0; sec_ready = 0;
        idle_inputs();
        @(negedge clk);
        t_reset();
        t_stage_only();
        t_commit_internal();
        t_freq();
        t_secondary();
        t_reset_clears();
        t_gate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule